// File: doc/BRIEF.md
# IrDA Multi-Mode Baud Generator

This block turns a 48 MHz reference clock into the timing enables that an infrared serial port needs. A 14-bit programmable divisor first produces a base tick. A fixed prescaler chosen by the active mode then divides that tick down to a one-cycle enable strobe. The prescaler is 16 in slow infrared mode, 6 in fast infrared mode, and alternates between 41 and 42 in medium infrared mode. The divisor is held in two byte-wide registers. Software may change it only while the mode field reads the disabled code.

A separate timer produces the interaction pulse when it is triggered. The pulse is held high for 77 reference cycles, which is about 1.6 us. In medium and fast modes a 341-cycle guard follows, which is about 7.1 us. During the guard further triggers are ignored. In slow mode only the high phase is produced. Any change of the mode field clears every counter and ends any pulse or guard in progress. Character framing and modulation belong to other blocks.

Top module: `irda_baud_gen`

## Requirements
- R1: After reset all three strobes, `sipOut` and `wrReject` are low, and the divisor is zero.
- R2: A write takes effect only while `modeSel` is 7 (disabled). `divLoWr` loads `wrData[7:0]` into divisor bits 7:0. `divHiWr` loads `wrData[5:0]` into divisor bits 13:8.
- R3: A divisor write while `modeSel` is not 7 leaves the divisor unchanged, and `wrReject` is high for exactly the next cycle. An accepted write never raises `wrReject`.
- R4: With `modeSel` = 2 (fast) and divisor D, `firStrobe` pulses for one cycle every 6*D clock cycles.
- R5: With `modeSel` = 0 (slow) and divisor D, `sirStrobe` pulses for one cycle every 16*D clock cycles.
- R6: With `modeSel` = 1 (medium) and divisor D, the gaps between successive `mirStrobe` pulses alternate between 41*D and 42*D cycles. The first pulse after a mode change uses 41*D.
- R7: Only the strobe of the selected mode ever pulses. Codes 3 to 7 produce no strobes.
- R8: A divisor of zero produces no strobes in any mode.
- R9: A change of `modeSel` clears all counters. The first strobe appears D*L cycles after the clock edge that sees the change, where L is the mode's prescale.
- R10: In modes 1 and 2, an accepted trigger drives `sipOut` high for exactly 77 cycles. A 341-cycle guard follows in which triggers are ignored. A trigger held high restarts the pulse after 342 low cycles.
- R11: In mode 0 the pulse is 77 cycles high with no guard. A trigger held high gives one low cycle between pulses.
- R12: A change of `modeSel` ends a pulse at once. Triggers have no effect in codes 3 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 3 | 0 slow, 1 medium, 2 fast, 7 disabled, others idle |
| divLoWr | input | 1 | Write strobe for divisor low byte |
| divHiWr | input | 1 | Write strobe for divisor high byte |
| wrData | input | 8 | Write data for either divisor byte |
| pulseTrig | input | 1 | Requests an interaction pulse |
| sirStrobe | output | 1 | Slow-mode sample enable |
| mirStrobe | output | 1 | Medium-mode sample enable |
| firStrobe | output | 1 | Fast-mode sample enable |
| sipOut | output | 1 | Interaction pulse output |
| wrReject | output | 1 | One-cycle flag for a locked-out divisor write |

## Verification
The bench builds the block with its default parameters: a 14-bit divisor, prescales of 16, 41/42 and 6, and a 77/341 pulse. The real pulse lengths stay in use because they are short in clock cycles. Divisor values of 1 to 3 bring many strobe periods in each mode within a few hundred cycles. A divisor of 257 puts both bytes in play within one long period.

// File: rtl/irda_bg_pkg.sv
package irda_bg_pkg;
  localparam logic [2:0] MODE_SIR = 3'd0;
  localparam logic [2:0] MODE_MIR = 3'd1;
  localparam logic [2:0] MODE_FIR = 3'd2;
  localparam logic [2:0] MODE_OFF = 3'd7;

  typedef struct packed {
    logic clearAll;
    logic loadLo;
    logic loadHi;
    logic enSir;
    logic enMir;
    logic enFir;
  } ctrlStrobes_t;
endpackage

// File: rtl/irda_bg_ctrl.sv
module irda_bg_ctrl
  import irda_bg_pkg::*;
#(
  parameter int PULSE_ON  = 77,
  parameter int PULSE_OFF = 341
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   modeSel,
  input  logic         divLoWr,
  input  logic         divHiWr,
  input  logic         pulseTrig,
  output ctrlStrobes_t ctl,
  output logic         wrReject,
  output logic         sipOut
);
  localparam int MAXP = (PULSE_ON > PULSE_OFF) ? PULSE_ON : PULSE_OFF;
  localparam int PCW  = (MAXP > 1) ? $clog2(MAXP) : 1;

  typedef enum logic [1:0] {PS_IDLE, PS_ON, PS_GUARD} pulseState_t;

  logic [2:0]  prevMode;
  logic        modeChange;
  logic        isOff;
  logic        anyEn;
  pulseState_t pState;
  logic [PCW-1:0] pCnt;

  assign modeChange = (modeSel != prevMode);
  assign isOff      = (modeSel == MODE_OFF);

  always_comb begin
    ctl.clearAll = modeChange;
    ctl.loadLo   = divLoWr && isOff;
    ctl.loadHi   = divHiWr && isOff;
    ctl.enSir    = (modeSel == MODE_SIR) && !modeChange;
    ctl.enMir    = (modeSel == MODE_MIR) && !modeChange;
    ctl.enFir    = (modeSel == MODE_FIR) && !modeChange;
  end

  assign anyEn = ctl.enSir || ctl.enMir || ctl.enFir;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevMode <= MODE_OFF;
      wrReject <= 1'b0;
    end else begin
      prevMode <= modeSel;
      wrReject <= (divLoWr || divHiWr) && !isOff;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || modeChange) begin
      pState <= PS_IDLE;
      pCnt   <= '0;
    end else begin
      case (pState)
        PS_IDLE: begin
          if (pulseTrig && anyEn) begin
            pState <= PS_ON;
            pCnt   <= '0;
          end
        end
        PS_ON: begin
          if (pCnt == PCW'(PULSE_ON - 1)) begin
            pCnt   <= '0;
            pState <= (modeSel == MODE_SIR) ? PS_IDLE : PS_GUARD;
          end else begin
            pCnt <= pCnt + 1'b1;
          end
        end
        PS_GUARD: begin
          if (pCnt == PCW'(PULSE_OFF - 1)) begin
            pCnt   <= '0;
            pState <= PS_IDLE;
          end else begin
            pCnt <= pCnt + 1'b1;
          end
        end
        default: pState <= PS_IDLE;
      endcase
    end
  end

  assign sipOut = (pState == PS_ON);
endmodule

// File: rtl/irda_bg_dp.sv
module irda_bg_dp
  import irda_bg_pkg::*;
#(
  parameter int DIV_W       = 14,
  parameter int LO_W        = 8,
  parameter int SIR_RATIO   = 16,
  parameter int MIR_RATIO_A = 41,
  parameter int MIR_RATIO_B = 42,
  parameter int FIR_RATIO   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     ctl,
  input  logic [LO_W-1:0]  wrData,
  output logic             sirStrobe,
  output logic             mirStrobe,
  output logic             firStrobe,
  output logic [DIV_W-1:0] divValue
);
  localparam int HI_W  = DIV_W - LO_W;
  localparam int MAXAB = (MIR_RATIO_A > MIR_RATIO_B) ? MIR_RATIO_A : MIR_RATIO_B;
  localparam int MAXSF = (SIR_RATIO > FIR_RATIO) ? SIR_RATIO : FIR_RATIO;
  localparam int MAXR  = (MAXAB > MAXSF) ? MAXAB : MAXSF;
  localparam int PRE_W = (MAXR > 1) ? $clog2(MAXR) : 1;
  localparam int NMODE = 3;

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] baseCnt;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] curLimit;
  logic             mirPhase;
  logic             anyEn;
  logic             hold;
  logic             baseTick;
  logic             preWrap;
  logic [NMODE-1:0] enVec;
  logic [NMODE-1:0] strobeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg <= '0;
    end else begin
      if (ctl.loadLo) divReg[LO_W-1:0]     <= wrData;
      if (ctl.loadHi) divReg[DIV_W-1:LO_W] <= wrData[HI_W-1:0];
    end
  end

  assign enVec    = {ctl.enFir, ctl.enMir, ctl.enSir};
  assign anyEn    = |enVec;
  assign hold     = ctl.clearAll || !anyEn || (divReg == '0);
  assign baseTick = !hold && (baseCnt == divReg - DIV_W'(1));

  always_comb begin
    if (ctl.enSir)      curLimit = PRE_W'(SIR_RATIO);
    else if (ctl.enMir) curLimit = mirPhase ? PRE_W'(MIR_RATIO_B) : PRE_W'(MIR_RATIO_A);
    else                curLimit = PRE_W'(FIR_RATIO);
  end

  assign preWrap = baseTick && (preCnt == curLimit - PRE_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN || hold) begin
      baseCnt <= '0;
    end else if (baseTick) begin
      baseCnt <= '0;
    end else begin
      baseCnt <= baseCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearAll || !anyEn) begin
      preCnt   <= '0;
      mirPhase <= 1'b0;
    end else if (baseTick) begin
      if (preWrap) begin
        preCnt <= '0;
        if (ctl.enMir) mirPhase <= ~mirPhase;
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  for (genvar g = 0; g < NMODE; g++) begin : gStrobe
    always_ff @(posedge clk) begin
      if (!rstN) strobeQ[g] <= 1'b0;
      else       strobeQ[g] <= preWrap && enVec[g];
    end
  end

  assign sirStrobe = strobeQ[0];
  assign mirStrobe = strobeQ[1];
  assign firStrobe = strobeQ[2];
  assign divValue  = divReg;
endmodule

// File: rtl/irda_baud_gen.sv
module irda_baud_gen
  import irda_bg_pkg::*;
#(
  parameter int DIV_W       = 14,
  parameter int LO_W        = 8,
  parameter int SIR_RATIO   = 16,
  parameter int MIR_RATIO_A = 41,
  parameter int MIR_RATIO_B = 42,
  parameter int FIR_RATIO   = 6,
  parameter int PULSE_ON    = 77,
  parameter int PULSE_OFF   = 341
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [2:0]      modeSel,
  input  logic            divLoWr,
  input  logic            divHiWr,
  input  logic [LO_W-1:0] wrData,
  input  logic            pulseTrig,
  output logic            sirStrobe,
  output logic            mirStrobe,
  output logic            firStrobe,
  output logic            sipOut,
  output logic            wrReject
);
  ctrlStrobes_t     ctl;
  logic [DIV_W-1:0] divValue;

  irda_bg_ctrl #(.PULSE_ON(PULSE_ON), .PULSE_OFF(PULSE_OFF)) ctrlI (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .divLoWr(divLoWr),
    .divHiWr(divHiWr), .pulseTrig(pulseTrig), .ctl(ctl),
    .wrReject(wrReject), .sipOut(sipOut)
  );

  irda_bg_dp #(
    .DIV_W(DIV_W), .LO_W(LO_W), .SIR_RATIO(SIR_RATIO),
    .MIR_RATIO_A(MIR_RATIO_A), .MIR_RATIO_B(MIR_RATIO_B), .FIR_RATIO(FIR_RATIO)
  ) dpI (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .sirStrobe(sirStrobe), .mirStrobe(mirStrobe), .firStrobe(firStrobe),
    .divValue(divValue)
  );
endmodule

// File: rtl/irda_baud_gen_chk.sv
module irda_baud_gen_chk #(
  parameter int DIV_W    = 14,
  parameter int PULSE_ON = 77
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       modeSel,
  input logic             divLoWr,
  input logic             divHiWr,
  input logic             sirStrobe,
  input logic             mirStrobe,
  input logic             firStrobe,
  input logic             sipOut,
  input logic             wrReject,
  input logic [DIV_W-1:0] divValue
);
  localparam int HCW = $clog2(PULSE_ON + 2);
  logic [HCW-1:0] highCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                          highCnt <= '0;
    else if (!sipOut)                   highCnt <= '0;
    else if (highCnt != {HCW{1'b1}})    highCnt <= highCnt + 1'b1;
  end

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sirStrobe, mirStrobe, firStrobe}));

  assert_reject_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((divLoWr || divHiWr) && modeSel != 3'd7) |=> wrReject);

  assert_no_false_reject_R3: assert property (@(posedge clk) disable iff (!rstN)
    !((divLoWr || divHiWr) && modeSel != 3'd7) |=> !wrReject);

  assert_divisor_locked_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != 3'd7) |=> $stable(divValue));

  assert_zero_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    (divValue == '0 && $past(divValue) == '0) |-> !(sirStrobe || mirStrobe || firStrobe));

  assert_mode_change_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != $past(modeSel)) |=> !(sipOut || sirStrobe || mirStrobe || firStrobe));

  assert_pulse_width_R10: assert property (@(posedge clk) disable iff (!rstN)
    sipOut |-> (highCnt < HCW'(PULSE_ON)));
endmodule

bind irda_baud_gen irda_baud_gen_chk #(.DIV_W(DIV_W), .PULSE_ON(PULSE_ON)) chkI (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .divLoWr(divLoWr), .divHiWr(divHiWr),
  .sirStrobe(sirStrobe), .mirStrobe(mirStrobe), .firStrobe(firStrobe),
  .sipOut(sipOut), .wrReject(wrReject), .divValue(divValue)
);

// File: tb/irda_baud_gen_test.sv
module irda_baud_gen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modeSel = 3'd7;
  logic       divLoWr = 1'b0;
  logic       divHiWr = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic       pulseTrig = 1'b0;
  logic       sirStrobe, mirStrobe, firStrobe, sipOut, wrReject;

  int checks = 0;
  int failures = 0;
  int otherHits = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irda_baud_gen uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .divLoWr(divLoWr), .divHiWr(divHiWr),
    .wrData(wrData), .pulseTrig(pulseTrig), .sirStrobe(sirStrobe), .mirStrobe(mirStrobe),
    .firStrobe(firStrobe), .sipOut(sipOut), .wrReject(wrReject)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setMode(input logic [2:0] m);
    @(negedge clk);
    modeSel = m;
  endtask

  task automatic writeDiv(input int value);
    setMode(3'd7);
    divLoWr = 1'b1; wrData = value[7:0];
    @(negedge clk);
    divLoWr = 1'b0; divHiWr = 1'b1; wrData = {2'b00, value[13:8]};
    @(negedge clk);
    divHiWr = 1'b0;
  endtask

  // Counts negedges until the selected strobe (0 sir, 1 mir, 2 fir) is seen high.
  task automatic waitStrobe(input int sel, input int maxc, output int n);
    logic [2:0] s;
    n = 0;
    while (n < maxc) begin
      @(negedge clk);
      n++;
      s = {firStrobe, mirStrobe, sirStrobe};
      if ((s & ~(3'b001 << sel)) != 3'b000) otherHits++;
      if (s[sel]) return;
    end
    n = -1;
  endtask

  task automatic countStrobes(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sirStrobe || mirStrobe || firStrobe) cnt++;
    end
  endtask

  task automatic measureRun(input logic level, input int maxc, output int n);
    n = 0;
    while (sipOut == level && n < maxc) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic testReset;
    @(negedge clk);
    check(!sirStrobe && !mirStrobe && !firStrobe && !sipOut && !wrReject, "R1 reset outputs",
          {sirStrobe, mirStrobe, firStrobe, sipOut, wrReject}, 0);
    rstN = 1'b1;
    setMode(3'd2);
    begin
      int c;
      countStrobes(100, c);
      check(c == 0, "R1 reset divisor is zero", c, 0);
    end
  endtask

  task automatic testFir;
    int n;
    writeDiv(2);
    otherHits = 0;
    setMode(3'd2);
    waitStrobe(2, 500, n);
    check(n == 13, "R9 fast first strobe latency", n, 13);
    waitStrobe(2, 500, n);
    check(n == 12, "R4 fast interval 1", n, 12);
    waitStrobe(2, 500, n);
    check(n == 12, "R4 fast interval 2", n, 12);
    check(otherHits == 0, "R7 only fast strobe", otherHits, 0);
  endtask

  task automatic testSir;
    int n;
    writeDiv(3);
    otherHits = 0;
    setMode(3'd0);
    waitStrobe(0, 500, n);
    check(n == 49, "R9 slow first strobe latency", n, 49);
    waitStrobe(0, 500, n);
    check(n == 48, "R5 slow interval", n, 48);
    check(otherHits == 0, "R7 only slow strobe", otherHits, 0);
  endtask

  task automatic testMir;
    int n;
    writeDiv(1);
    otherHits = 0;
    setMode(3'd1);
    waitStrobe(1, 500, n);
    check(n == 42, "R6 medium first gap 41", n, 42);
    waitStrobe(1, 500, n);
    check(n == 42, "R6 medium gap 42", n, 42);
    waitStrobe(1, 500, n);
    check(n == 41, "R6 medium gap 41", n, 41);
    waitStrobe(1, 500, n);
    check(n == 42, "R6 medium gap 42 again", n, 42);
    check(otherHits == 0, "R7 only medium strobe", otherHits, 0);
  endtask

  task automatic testHighByte;
    int n;
    writeDiv(257);
    setMode(3'd2);
    waitStrobe(2, 4000, n);
    waitStrobe(2, 4000, n);
    check(n == 1542, "R2 high byte in divisor", n, 1542);
  endtask

  task automatic testLockout;
    int n;
    writeDiv(2);
    @(negedge clk);
    check(wrReject == 1'b0, "R3 accepted write no reject", wrReject, 0);
    setMode(3'd2);
    waitStrobe(2, 500, n);
    divLoWr = 1'b1; wrData = 8'd5;
    @(negedge clk);
    divLoWr = 1'b0;
    check(wrReject == 1'b1, "R3 reject flag raised", wrReject, 1);
    @(negedge clk);
    check(wrReject == 1'b0, "R3 reject flag one cycle", wrReject, 0);
    waitStrobe(2, 500, n);
    waitStrobe(2, 500, n);
    check(n == 12, "R3 locked write ignored", n, 12);
  endtask

  task automatic testZeroDiv;
    int c;
    writeDiv(0);
    setMode(3'd2);
    countStrobes(300, c);
    check(c == 0, "R8 zero divisor fast silent", c, 0);
    setMode(3'd1);
    countStrobes(300, c);
    check(c == 0, "R8 zero divisor medium silent", c, 0);
  endtask

  task automatic testIdleCodes;
    int c;
    int hi;
    writeDiv(1);
    setMode(3'd4);
    pulseTrig = 1'b1;
    hi = 0;
    c = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sirStrobe || mirStrobe || firStrobe) c++;
      if (sipOut) hi++;
    end
    pulseTrig = 1'b0;
    check(c == 0, "R7 code 4 no strobes", c, 0);
    check(hi == 0, "R12 trigger ignored in code 4", hi, 0);
    setMode(3'd7);
    countStrobes(100, c);
    check(c == 0, "R7 disabled no strobes", c, 0);
  endtask

  task automatic testPulseGuard;
    int n;
    setMode(3'd1);
    @(negedge clk);
    pulseTrig = 1'b1;
    @(negedge clk);
    check(sipOut == 1'b1, "R10 pulse starts", sipOut, 1);
    measureRun(1'b1, 1000, n);
    check(n == 77, "R10 pulse high time", n, 77);
    measureRun(1'b0, 1000, n);
    check(n == 342, "R10 guard with held trigger", n, 342);
    measureRun(1'b1, 1000, n);
    check(n == 77, "R10 second pulse high time", n, 77);
    pulseTrig = 1'b0;
    measureRun(1'b0, 1000, n);
  endtask

  task automatic testPulseSir;
    int n;
    setMode(3'd0);
    @(negedge clk);
    pulseTrig = 1'b1;
    @(negedge clk);
    measureRun(1'b1, 1000, n);
    check(n == 77, "R11 slow pulse high time", n, 77);
    measureRun(1'b0, 1000, n);
    check(n == 1, "R11 slow no guard", n, 1);
    pulseTrig = 1'b0;
    measureRun(1'b1, 1000, n);
    check(n == 77, "R11 slow retrigger", n, 77);
  endtask

  task automatic testPulseAbort;
    setMode(3'd2);
    @(negedge clk);
    pulseTrig = 1'b1;
    @(negedge clk);
    pulseTrig = 1'b0;
    repeat (10) @(negedge clk);
    check(sipOut == 1'b1, "R12 pulse running before change", sipOut, 1);
    modeSel = 3'd1;
    @(negedge clk);
    check(sipOut == 1'b0, "R12 mode change ends pulse", sipOut, 0);
    pulseTrig = 1'b1;
    @(negedge clk);
    pulseTrig = 1'b0;
    check(sipOut == 1'b1, "R12 trigger accepted after abort", sipOut, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testFir();
    testSir();
    testMir();
    testHighByte();
    testLockout();
    testZeroDiv();
    testIdleCodes();
    testPulseGuard();
    testPulseSir();
    testPulseAbort();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule